// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges three independent reset causes into a single processor reset that is driven both active-low and active-high. The causes are a digital undervoltage flag from an external supply comparator, an active-low manual reset pin (for example a push-button), and a one-cycle timeout strobe from a watchdog counter. Each cause can start a reset. The reset is then stretched by a fixed hold period, which counts from the moment the last active cause goes away.

The two asynchronous inputs are synchronised first. Each then passes through a filter that ignores it until it has stayed at its active level for a parameterised number of cycles. In this way, push-button glitches and brief supply dips do not reach the processor. After the block's own reset, the output is asserted and waits one full hold period before the first release. A one-cycle entry strobe marks every transition from released to asserted, and the watchdog uses it to clear itself. While the reset level is asserted, the watchdog stays frozen.

Top module: `sup_reset_gen`

## Requirements
- R1: After rst_ni is released with no cause present, rst_o stays high for HOLD_CYCLES cycles and then falls.
- R2: A one-cycle wdt_expire_i pulse drives rst_o high on the next clock edge and holds it for HOLD_CYCLES cycles.
- R3: When mr_ni is held low for L >= MR_MIN_CYCLES cycles, rst_o rises SYNC_STAGES+MR_MIN_CYCLES+1 edges after the first low sample and stays high for L-MR_MIN_CYCLES+HOLD_CYCLES cycles.
- R4: A low pulse on mr_ni shorter than MR_MIN_CYCLES cycles produces no reset.
- R5: When uv_flag_i (high means undervoltage) is held high for L >= UV_MIN_CYCLES cycles, rst_o is held for L-UV_MIN_CYCLES+HOLD_CYCLES cycles.
- R6: A high pulse on uv_flag_i shorter than UV_MIN_CYCLES cycles produces no reset.
- R7: rst_no is always the inverse of rst_o.
- R8: A cause that arrives during the hold period keeps reset asserted, and the hold count restarts from zero once that cause ends.
- R9: rst_enter_o pulses high for exactly one cycle, in the first cycle rst_o is high after being low. It does not pulse for causes that arrive while reset is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| uv_flag_i | input | 1 | Undervoltage flag from the comparator, high = supply low (asynchronous) |
| mr_ni | input | 1 | Manual reset, active low; ties high when unused (asynchronous) |
| wdt_expire_i | input | 1 | One-cycle watchdog timeout strobe, same clock domain |
| rst_no | output | 1 | Active-low reset to the processor |
| rst_o | output | 1 | Active-high reset to the processor |
| rst_enter_o | output | 1 | One-cycle strobe on each entry into reset |

## Verification
The bench drives each cause on its own and measures the width of every reset pulse against the width the formulas predict. A single watchdog strobe isolates the hold counter. Manual and supply pulses, one exactly at the filter limit and one well beyond it, separate the filter length from the hold length. Pulses one and two cycles under the limit show that the filters reject them. A second watchdog strobe inside the hold window checks that the counter restarts rather than extends. Counting entry strobes against released-to-asserted transitions separates a fresh entry from a re-trigger during the hold.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RESET_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_glitch_filt.sv
module sup_glitch_filt
  import sup_rst_pkg::*;
#(
  parameter int MIN_CYCLES = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic act_o
);

  localparam int             CW  = cnt_w(MIN_CYCLES);
  localparam logic [CW-1:0]  LIM = CW'(MIN_CYCLES - 1);

  logic          raw_act;
  logic [CW-1:0] run_q;
  logic          act_q;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign raw_act = ~in_i;
    end else begin : g_high
      assign raw_act = in_i;
    end
  endgenerate

  // act rises once raw_act has been sampled MIN_CYCLES times in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      act_q <= 1'b0;
    end else if (!raw_act) begin
      run_q <= '0;
      act_q <= 1'b0;
    end else if (run_q >= LIM) begin
      act_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
  import sup_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic asserted_o,
  output logic enter_o
);

  localparam int            HW  = cnt_w(HOLD_CYCLES);
  localparam logic [HW-1:0] LIM = HW'(HOLD_CYCLES - 1);

  hold_state_e   state_q;
  logic [HW-1:0] cnt_q;
  logic          enter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      enter_q <= 1'b0;
    end else if (cause_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      enter_q <= (state_q == ST_RUN);
    end else begin
      enter_q <= 1'b0;
      if (state_q == ST_HOLD) begin
        if (cnt_q == LIM) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign asserted_o = (state_q == ST_HOLD);
  assign enter_o    = enter_q;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int HOLD_CYCLES   = 40_000_000, // 200 ms at 200 MHz
  parameter int MR_MIN_CYCLES = 40,         // 200 ns
  parameter int UV_MIN_CYCLES = 2000,       // 10 us
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_flag_i,
  input  logic mr_ni,
  input  logic wdt_expire_i,
  output logic rst_no,
  output logic rst_o,
  output logic rst_enter_o
);

  logic mr_s, uv_s;
  logic mr_act, uv_act;
  logic cause;
  logic asserted;

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_mr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mr_ni), .q_o(mr_s)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_uv_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(uv_flag_i), .q_o(uv_s)
  );

  sup_glitch_filt #(.MIN_CYCLES(MR_MIN_CYCLES), .ACTIVE_LOW(1'b1)) u_mr_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(mr_s), .act_o(mr_act)
  );

  sup_glitch_filt #(.MIN_CYCLES(UV_MIN_CYCLES), .ACTIVE_LOW(1'b0)) u_uv_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(uv_s), .act_o(uv_act)
  );

  assign cause = mr_act | uv_act | wdt_expire_i;

  sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(cause),
    .asserted_o(asserted), .enter_o(rst_enter_o)
  );

  assign rst_o  = asserted;
  assign rst_no = ~asserted;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_flag_i,
  input logic mr_ni,
  input logic wdt_expire_i,
  input logic rst_no,
  input logic rst_o,
  input logic rst_enter_o
);

  a_r2_wdt_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_expire_i |=> rst_o);

  a_r2_no_release_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> !$past(wdt_expire_i));

  a_r7_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no != rst_o);

  a_r9_enter_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> rst_enter_o);

  a_r9_enter_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_enter_o |=> !rst_enter_o);

  a_r9_enter_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_enter_o |-> rst_o);

endmodule

bind sup_reset_gen sup_reset_gen_chk chk_i (.*);

// File: tb/sup_reset_gen_tb.sv
`timescale 1ns/1ps
module sup_reset_gen_tb_top;

  localparam int HOLD = 40;
  localparam int MRF  = 5;
  localparam int UVF  = 12;
  localparam int SYN  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uv_flag_i = 1'b0;
  logic mr_ni = 1'b1;
  logic wdt_expire_i = 1'b0;
  logic rst_no, rst_o, rst_enter_o;

  always #2.5 clk = ~clk;

  sup_reset_gen #(
    .HOLD_CYCLES(HOLD), .MR_MIN_CYCLES(MRF), .UV_MIN_CYCLES(UVF), .SYNC_STAGES(SYN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .uv_flag_i(uv_flag_i), .mr_ni(mr_ni),
    .wdt_expire_i(wdt_expire_i), .rst_no(rst_no), .rst_o(rst_o),
    .rst_enter_o(rst_enter_o)
  );

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  int width = 0;
  bit prev = 1'b1;
  int pulses = 0;
  int enters = 0;
  int comp_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_pulse(input int w, input string req);
    exp_q.push_back(w);
    tag_q.push_back(req);
  endtask

  // monitor: measures each reset pulse, pops the expected width
  always @(negedge clk) begin
    if (!rst_ni) begin
      width = 0;
      prev  = 1'b1;
    end else begin
      if (rst_no == rst_o) comp_err++;
      if (rst_enter_o) enters++;
      if (rst_o) width++;
      else if (prev) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R6", "unexpected reset pulse width", width, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(width >= e - 1 && width <= e + 1, t, "pulse width", width, e);
        end
        width = 0;
      end
      prev = rst_o;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wdt_pulse();
    wdt_expire_i = 1'b1;
    cyc(1);
    wdt_expire_i = 1'b0;
  endtask

  task automatic mr_low(input int n);
    mr_ni = 1'b0;
    cyc(n);
    mr_ni = 1'b1;
  endtask

  task automatic uv_high(input int n);
    uv_flag_i = 1'b1;
    cyc(n);
    uv_flag_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    cyc(3);
    chk(rst_o == 1'b1 && rst_no == 1'b0, "R1", "reset state rst_o", rst_o, 1);
    expect_pulse(HOLD, "R1");
    rst_ni = 1'b1;
    cyc(HOLD - 3);
    chk(rst_o == 1'b1, "R1", "still held before hold end", rst_o, 1);
    cyc(15);
    chk(rst_o == 1'b0, "R1", "released after hold", rst_o, 0);

    // R2 single watchdog strobe
    expect_pulse(HOLD, "R2");
    wdt_pulse();
    chk(rst_o == 1'b1, "R2", "assert one edge after strobe", rst_o, 1);
    cyc(HOLD + 10);

    // R8 second strobe 10 cycles into hold restarts counter
    expect_pulse(HOLD + 10, "R8");
    wdt_pulse();
    cyc(9);
    wdt_pulse();
    cyc(HOLD + 10);

    // R3 manual reset latency and width
    expect_pulse(20 - MRF + HOLD, "R3");
    mr_ni = 1'b0;
    cyc(SYN + MRF);
    chk(rst_o == 1'b0, "R3", "not yet asserted", rst_o, 0);
    cyc(1);
    chk(rst_o == 1'b1, "R3", "asserted at latency", rst_o, 1);
    cyc(20 - SYN - MRF - 1);
    mr_ni = 1'b1;
    cyc(HOLD + 20);

    // R3 boundary: exactly MR_MIN_CYCLES
    expect_pulse(HOLD, "R3");
    mr_low(MRF);
    cyc(HOLD + 20);

    // R4 short manual pulses ignored
    p0 = pulses;
    mr_low(MRF - 1);
    cyc(20);
    chk(rst_o == 1'b0, "R4", "rst_o after short mr", rst_o, 0);
    mr_low(MRF - 2);
    cyc(20);
    chk(pulses == p0, "R4", "pulses after short mr", pulses, p0);

    // R5 undervoltage long and boundary
    expect_pulse(30 - UVF + HOLD, "R5");
    uv_high(30);
    cyc(HOLD + 20);
    expect_pulse(HOLD, "R5");
    uv_high(UVF);
    cyc(HOLD + 20);

    // R6 short dip ignored
    p0 = pulses;
    uv_high(UVF - 1);
    cyc(25);
    chk(rst_o == 1'b0, "R6", "rst_o after short dip", rst_o, 0);
    chk(pulses == p0, "R6", "pulses after short dip", pulses, p0);

    // R9 entry strobes: R2, R8, R3 x2, R5 x2
    chk(enters == 6, "R9", "entry strobe count", enters, 6);
    chk(comp_err == 0, "R7", "complement mismatches", comp_err, 0);
    chk(exp_q.size() == 0, "R1", "expected pulses left", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule